// File: doc/BRIEF.md
# Microprogram Sequencer Slice

This block is a cascadable slice of a microprogram address sequencer. Every cycle it forms the address of the next microinstruction on its `y` output. The address comes from one of four sources: a counter register, an address register, the top entry of a small return stack, or a direct data input. Two override stages follow the source choice. The first is a per-bit OR force, which lets external condition logic set individual address bits high for conditional branches. The second is an active-low zero force, which sends the sequencer back to word zero.

The counter register is loaded on every rising edge with `y` plus the carry-in. With carry-in high the program advances by one. With carry-in low the same word repeats. The carry-out goes high when carry-in is high and `y` is all ones. Several slices can therefore be chained into 8-bit or 12-bit address generators by feeding each slice's carry-out into the next slice's carry-in.

The return stack holds return linkage for nested subroutines. A push moves the pointer up and stores the counter value in the new top entry. A pop moves the pointer down. The entry under the pointer is always available as a source, so a loop can be closed without changing the stack. The output drive is modelled as a drive flag that travels alongside `y`, so no tri-state net is used. A parameter selects a reduced variant: in that variant the OR inputs are ignored and the address register loads from the direct inputs.

Top module: `useq_slice`

## Requirements
- R1: The 2-bit select `sel` chooses the source of `y` (with `zero_n` high and `or_in` zero): 00 selects the counter register, 01 the address register, 10 the stack entry under the pointer, and 11 the direct input `d`.
- R2: On a rising edge, the address register loads `r` when `reg_en_n` is low. When `reg_en_n` is high it keeps its value.
- R3: On every rising edge, the counter register loads `y` plus `cin`, modulo 2^WIDTH. It takes `y`+1 when `cin` is 1 and `y` unchanged when `cin` is 0.
- R4: `cout` is 1 exactly when `cin` is 1 and `y` is all ones. After such a cycle the counter register holds zero.
- R5: When `zero_n` is low, `y` is all zeros whatever the values of `sel`, `or_in` and the sources.
- R6: When `zero_n` is high, each bit of `y` is the selected source bit ORed with the matching bit of `or_in`.
- R7: `y_drv` is 1 when `oe_n` is low and 0 when `oe_n` is high. `oe_n` does not alter `y` or any register.
- R8: With `fe_n` low and `pup` high (push), the pointer advances by one on the rising edge. The new top entry receives the counter register value held before that edge.
- R9: With `fe_n` low and `pup` low (pop), the pointer steps back by one. With `fe_n` high, the pointer and the stack entries keep their values whatever `pup` is.
- R10: The pointer wraps modulo DEPTH (4). A fifth push without a pop overwrites the oldest entry, and a pop at the bottom entry wraps to the highest entry.
- R11: A synchronous active-high `rst` clears the counter register, the address register, the pointer and all stack entries to zero.
- R12: With parameter HAS_OR = 0, `or_in` has no effect on `y`, and the address register loads from `d` instead of `r`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| d | input | WIDTH | Direct address input |
| r | input | WIDTH | Address register data input |
| reg_en_n | input | 1 | Active-low address register load enable |
| sel | input | 2 | Source select code |
| fe_n | input | 1 | Active-low stack enable |
| pup | input | 1 | Stack direction: 1 push, 0 pop |
| cin | input | 1 | Incrementer carry-in |
| or_in | input | WIDTH | Per-bit OR force |
| zero_n | input | 1 | Active-low force of `y` to zero |
| oe_n | input | 1 | Active-low output drive enable |
| y | output | WIDTH | Next microinstruction address |
| cout | output | 1 | Incrementer carry-out |
| y_drv | output | 1 | Output drive flag (0 means high impedance) |

## Verification
The stack contents are hardest to reach from the ports. They become visible only when `sel` is 10, and only the entry under the pointer shows. Wraparound therefore needs runs of five or more pushes, or pops taken from the bottom entry. Each of those operations must also be followed by a read. Directed bursts of pushes, with each pushed value made distinct by driving `y` from `d`, are followed by pop-and-read sequences. Random cycles then mix stack operations with reads at high weight. The carry-out wrap also depends on an all-ones `y` coinciding with a high `cin`, and a directed case forces this through `d` and `or_in`.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [1:0] {
        SRC_PC  = 2'b00,
        SRC_AR  = 2'b01,
        SRC_STK = 2'b10,
        SRC_DIR = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        STK_HOLD = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10
    } stk_op_e;
endpackage

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
    import useq_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit HAS_OR = 1'b1
) (
    input  logic [WIDTH-1:0] pc_q,
    input  logic [WIDTH-1:0] ar_q,
    input  logic [WIDTH-1:0] stk_top,
    input  logic [WIDTH-1:0] d,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] or_in,
    input  logic             zero_n,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] forced;

    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_PC:  src = pc_q;
            SRC_AR:  src = ar_q;
            SRC_STK: src = stk_top;
            SRC_DIR: src = d;
        endcase
    end

    generate
        if (HAS_OR) begin : g_or
            assign forced = src | or_in;
        end else begin : g_no_or
            assign forced = src;
        end
    endgenerate

    assign y = zero_n ? forced : '0;
endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack
    import useq_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fe_n,
    input  logic             pup,
    input  logic [WIDTH-1:0] pc_in,
    output logic [WIDTH-1:0] stk_top
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    sp;
    logic [PW-1:0]    sp_up;
    logic [PW-1:0]    sp_dn;
    stk_op_e          op;

    always_comb begin
        op = STK_HOLD;
        if (!fe_n) op = pup ? STK_PUSH : STK_POP;
    end

    assign sp_up   = (sp == LAST) ? '0 : sp + 1'b1;
    assign sp_dn   = (sp == '0) ? LAST : sp - 1'b1;
    assign stk_top = mem[sp];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            unique case (op)
                STK_PUSH: begin
                    sp      <= sp_up;
                    mem[sp_up] <= pc_in;
                end
                STK_POP:  sp <= sp_dn;
                default:  begin end
            endcase
        end
    end

    AST_STACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        fe_n |=> ($stable(sp) && $stable(stk_top))); // R9
    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        (!fe_n && pup) |=> (stk_top == $past(pc_in))); // R8
endmodule

// File: rtl/useq_slice.sv
module useq_slice
    import useq_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int DEPTH  = 4,
    parameter bit HAS_OR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] r,
    input  logic             reg_en_n,
    input  logic [1:0]       sel,
    input  logic             fe_n,
    input  logic             pup,
    input  logic             cin,
    input  logic [WIDTH-1:0] or_in,
    input  logic             zero_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] y,
    output logic             cout,
    output logic             y_drv
);
    logic [WIDTH-1:0] pc_q;
    logic [WIDTH-1:0] ar_q;
    logic [WIDTH-1:0] ar_src;
    logic [WIDTH-1:0] stk_top;

    assign ar_src = HAS_OR ? r : d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ar_q <= '0;
        end else begin
            pc_q <= y + WIDTH'(cin);
            if (!reg_en_n) ar_q <= ar_src;
        end
    end

    useq_ret_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .fe_n    (fe_n),
        .pup     (pup),
        .pc_in   (pc_q),
        .stk_top (stk_top)
    );

    useq_addr_mux #(.WIDTH(WIDTH), .HAS_OR(HAS_OR)) u_mux (
        .pc_q    (pc_q),
        .ar_q    (ar_q),
        .stk_top (stk_top),
        .d       (d),
        .sel     (sel),
        .or_in   (or_in),
        .zero_n  (zero_n),
        .y       (y)
    );

    assign cout  = cin & (&y);
    assign y_drv = ~oe_n;

    AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (rst)
        !zero_n |-> (y == '0)); // R5
    AST_PC_REPEAT: assert property (@(posedge clk) disable iff (rst)
        !cin |=> (pc_q == $past(y))); // R3
    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (rst)
        cout |=> (pc_q == '0)); // R4
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
        reg_en_n |=> $stable(ar_q)); // R2
endmodule

// File: tb/sim_useq_slice.sv
module sim_useq_slice;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] d = '0, r = '0, or_in = '0;
    logic       reg_en_n = 1'b1, fe_n = 1'b1, pup = 1'b0, cin = 1'b0;
    logic       zero_n = 1'b1, oe_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [3:0] y, y1;
    logic       cout, y_drv, cout1, y_drv1;

    int n_cmp = 0;
    int n_bad = 0;

    logic [3:0] m_pc, m_ar;
    logic [3:0] m_stk [4];
    int         m_sp;

    always #2 clk = ~clk;

    useq_slice u0 (
        .clk(clk), .rst(rst), .d(d), .r(r), .reg_en_n(reg_en_n), .sel(sel),
        .fe_n(fe_n), .pup(pup), .cin(cin), .or_in(or_in), .zero_n(zero_n),
        .oe_n(oe_n), .y(y), .cout(cout), .y_drv(y_drv)
    );

    useq_slice #(.HAS_OR(1'b0)) u1 (
        .clk(clk), .rst(rst), .d(d), .r(r), .reg_en_n(reg_en_n), .sel(sel),
        .fe_n(fe_n), .pup(pup), .cin(cin), .or_in(or_in), .zero_n(zero_n),
        .oe_n(oe_n), .y(y1), .cout(cout1), .y_drv(y_drv1)
    );

    function automatic logic [3:0] exp_y();
        logic [3:0] s;
        case (sel)
            2'b00:   s = m_pc;
            2'b01:   s = m_ar;
            2'b10:   s = m_stk[m_sp];
            default: s = d;
        endcase
        return zero_n ? (s | or_in) : 4'h0;
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pc = '0; m_ar = '0; m_sp = 0;
        for (int i = 0; i < 4; i++) m_stk[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
    endtask

    task automatic apply(input logic [3:0] d_, input logic [3:0] r_, input logic ren_,
                         input logic [1:0] s_, input logic fe_, input logic pup_,
                         input logic cin_, input logic [3:0] or_, input logic z_,
                         input logic oe_);
        @(negedge clk);
        rst = 1'b0;
        d = d_; r = r_; reg_en_n = ren_; sel = s_; fe_n = fe_; pup = pup_;
        cin = cin_; or_in = or_; zero_n = z_; oe_n = oe_;
        #1;
    endtask

    task automatic check_main(input string tag);
        logic [3:0] ey;
        ey = exp_y();
        check(tag, y, ey);
        check("R4", {3'b0, cout}, {3'b0, cin & (&ey)});
        check("R7", {3'b0, y_drv}, {3'b0, ~oe_n});
    endtask

    task automatic clk_adv();
        logic [3:0] ey;
        ey = exp_y();
        @(posedge clk);
        if (!fe_n && pup) begin
            m_sp = (m_sp + 1) % 4;
            m_stk[m_sp] = m_pc;
        end else if (!fe_n && !pup) begin
            m_sp = (m_sp + 3) % 4;
        end
        m_pc = ey + {3'b0, cin};
        if (!reg_en_n) m_ar = r;
    endtask

    task automatic step(input string tag, input logic [3:0] d_, input logic [3:0] r_,
                        input logic ren_, input logic [1:0] s_, input logic fe_,
                        input logic pup_, input logic cin_, input logic [3:0] or_,
                        input logic z_, input logic oe_);
        apply(d_, r_, ren_, s_, fe_, pup_, cin_, or_, z_, oe_);
        check_main(tag);
        clk_adv();
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        model_reset();
        do_reset();
        // R11: all sources read zero right after reset
        step("R11", 4'h0, 4'h0, 1, 2'b00, 1, 0, 0, 4'h0, 1, 0);
        step("R11", 4'h0, 4'h0, 1, 2'b01, 1, 0, 0, 4'h0, 1, 0);
        step("R11", 4'h0, 4'h0, 1, 2'b10, 1, 0, 0, 4'h0, 1, 0);
        // R1: direct input selection
        step("R1", 4'h9, 4'h0, 1, 2'b11, 1, 0, 0, 4'h0, 1, 0);
        // R3: hold with cin=0, then increment
        step("R3", 4'h0, 4'h0, 1, 2'b00, 1, 0, 0, 4'h0, 1, 0);
        step("R3", 4'h0, 4'h0, 1, 2'b00, 1, 0, 1, 4'h0, 1, 0);
        step("R3", 4'h0, 4'h0, 1, 2'b00, 1, 0, 1, 4'h0, 1, 0);
        // R4: all-ones with carry in wraps counter to zero
        step("R4", 4'hF, 4'h0, 1, 2'b11, 1, 0, 1, 4'h0, 1, 0);
        step("R4", 4'h0, 4'h0, 1, 2'b00, 1, 0, 0, 4'h0, 1, 0);
        step("R4", 4'h3, 4'h0, 1, 2'b11, 1, 0, 1, 4'hC, 1, 0);
        // R2: load then hold the address register
        step("R2", 4'h0, 4'hA, 0, 2'b01, 1, 0, 0, 4'h0, 1, 0);
        step("R2", 4'h0, 4'h3, 1, 2'b01, 1, 0, 0, 4'h0, 1, 0);
        step("R2", 4'h0, 4'h5, 1, 2'b01, 1, 0, 0, 4'h0, 1, 0);
        // R5 / R6: zero force dominates OR force
        step("R5", 4'hF, 4'h0, 1, 2'b11, 1, 0, 0, 4'hF, 0, 0);
        step("R6", 4'h1, 4'h0, 1, 2'b11, 1, 0, 0, 4'h6, 1, 0);
        // R7: output disabled, registers unaffected
        step("R7", 4'h2, 4'h0, 1, 2'b11, 1, 0, 0, 4'h0, 1, 1);
        step("R7", 4'h0, 4'h0, 1, 2'b01, 1, 0, 0, 4'h0, 1, 1);
        // R8: push distinct counter values then read top
        for (int i = 0; i < 3; i++) begin
            step("R8", 4'(i + 5), 4'h0, 1, 2'b11, 1, 0, 0, 4'h0, 1, 0);
            step("R8", 4'h0, 4'h0, 1, 2'b10, 0, 1, 0, 4'h0, 1, 0);
        end
        step("R8", 4'h0, 4'h0, 1, 2'b10, 1, 0, 0, 4'h0, 1, 0);
        // R9: idle keeps top, pop exposes previous entry
        step("R9", 4'h0, 4'h0, 1, 2'b10, 1, 1, 0, 4'h0, 1, 0);
        step("R9", 4'h0, 4'h0, 1, 2'b10, 0, 0, 0, 4'h0, 1, 0);
        step("R9", 4'h0, 4'h0, 1, 2'b10, 1, 0, 0, 4'h0, 1, 0);
        // R10: six pushes wrap and overwrite, pops wrap through bottom
        for (int i = 0; i < 6; i++) begin
            step("R10", 4'(i + 8), 4'h0, 1, 2'b11, 1, 0, 0, 4'h0, 1, 0);
            step("R10", 4'h0, 4'h0, 1, 2'b10, 0, 1, 0, 4'h0, 1, 0);
        end
        for (int i = 0; i < 6; i++) begin
            step("R10", 4'h0, 4'h0, 1, 2'b10, 0, 0, 0, 4'h0, 1, 0);
        end
        // R12: reduced variant ignores OR and loads AR from d
        do_reset();
        apply(4'h5, 4'h9, 0, 2'b11, 1, 0, 0, 4'hF, 1, 0);
        check("R12", y1, 4'h5);
        clk_adv();
        apply(4'h0, 4'h9, 1, 2'b01, 1, 0, 0, 4'h0, 1, 0);
        check("R12", y1, 4'h5);
        check("R2", y, 4'h9);
        clk_adv();
        // random phase, fixed seed
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 200) == 0) do_reset();
            step(($urandom % 2) ? "R1" : "R6",
                 4'($urandom), 4'($urandom), 1'($urandom), 2'($urandom),
                 1'(($urandom % 3) == 0), 1'($urandom), 1'($urandom),
                 (($urandom % 4) == 0) ? 4'($urandom) : 4'h0,
                 1'(($urandom % 10) != 0), 1'(($urandom % 8) == 0));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule